// File: doc/BRIEF.md
# Adaptive Engine Gating Controller

This block decides how many packet-processing engines should be running. It watches two load indicators. The first is the depth of the queue of threads waiting for work. The second is a flag raised when the receive buffer is full. From these it drives one enable bit per engine, which the surrounding logic uses to stop or restart that engine's clock. A stopped engine keeps its instruction store, so it can start again at once without being reloaded. Draining threads from an engine and steering packets away from it are the job of other logic.

A saturating pressure counter adds one in every cycle in which the queue depth is strictly above a programmable limit. When the counter rises above an adaptive shed threshold, the controller stops the highest-numbered running engine and lowers the threshold by a programmable step. When the buffer reports full, it restarts the lowest-numbered stopped engine and raises the threshold by the same step. Both decisions clear the counter. Each change in load therefore moves the point at which the next engine is shed, which gives the controller hysteresis. The threshold is clamped between a minimum and a maximum set by parameters.

The controller has three states. WATCH is the state where it accumulates pressure and makes decisions. SHED is a one-cycle state that stops an engine and lowers the threshold. WAKE is a one-cycle state that restarts an engine and raises the threshold. The transitions are:
- WATCH to WAKE when the buffer is full and there is room to add an engine (the "grow" transition).
- WATCH to SHED when the buffer is not full, the counter is above the threshold and more than one engine is running (the "trim" transition).
- SHED to WATCH and WAKE to WATCH unconditionally (the "settle" transitions).

An input caps how many engines are present at all.

Top module: `adaptive_gate_ctrl`

## Requirements
- R1: After reset, engines 0 to eng_count-1 are enabled, the shed threshold equals THR_INIT (default 20) and the pressure counter is zero.
- R2: The pressure counter advances only in WATCH cycles in which q_depth is strictly greater than q_limit. A depth equal to the limit adds nothing. The counter holds when the depth is low and saturates at its maximum.
- R3: A trim occurs when the counter exceeds the threshold. It is decided at one edge and applied at the next, so under constant pressure starting from a cleared counter, the mask changes exactly threshold+3 cycles later. The counter is cleared when the trim is applied.
- R4: Each trim lowers the threshold by step, clamped at THR_MIN (default 4).
- R5: A full buffer sampled in WATCH enables one more engine two edges later. It raises the threshold by step, clamped at THR_MAX (default 40), and clears the counter.
- R6: At least one engine is always enabled, and no trim happens while a single engine runs.
- R7: A full buffer is ignored while every allowed engine is already enabled, and the mask does not change.
- R8: While the buffer is full, no trim is made, even if the counter is above the threshold. Growing takes precedence over trimming.
- R9: The number of allowed engines is eng_count, with 0 treated as 1 and values above N_ENG treated as N_ENG. Lowering eng_count shrinks the mask at once. Raising it enables nothing until a later grow.
- R10: With eng_count steady, the mask changes by at most one bit per cycle. Trims clear the highest enabled bit, and grows set the lowest cleared bit.
- R11: The mask is always a contiguous run of ones starting at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_depth | input | QW | Current thread-queue depth |
| q_limit | input | QW | Depth above which a cycle counts as pressure |
| buf_full | input | 1 | Receive buffer full indicator |
| step | input | CNT_W | Amount the shed threshold moves per decision |
| eng_count | input | AW | Number of engines present |
| eng_en | output | N_ENG | Per-engine enable mask, bit i drives engine i |

## Verification
The checker checks, on every cycle, the properties that hold regardless of timing. The mask keeps its shape and never goes empty. It changes by at most one bit at a time. The threshold stays within its clamps and moves in the direction set by each decision. A trim clears the counter, and a full buffer blocks every trim and every useless grow. The exact number of cycles between successive trims can only be shown by the bench's scenarios. So can the saturation of the threshold at both ends, the floor of one engine, the precedence of a full buffer followed by the trim when it is released, and the effect of the engine cap. The bench infers the hidden threshold from the measured intervals between trims.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_SHED  = 2'd1,
        ST_WAKE  = 2'd2
    } agc_state_e;

endpackage

// File: rtl/agc_sat_counter.sv
module agc_sat_counter #(
    parameter int W = 16
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc && value != TOP) begin
            value <= value + W'(1);
        end
    end
endmodule

// File: rtl/agc_adapt_thr.sv
module agc_adapt_thr #(
    parameter int W    = 16,
    parameter int MIN  = 4,
    parameter int MAX  = 40,
    parameter int INIT = 20
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lower,
    input  logic         raise,
    input  logic [W-1:0] step,
    output logic [W-1:0] thr
);
    localparam logic [W:0] MIN_X = (W+1)'(MIN);
    localparam logic [W:0] MAX_X = (W+1)'(MAX);

    logic [W:0] dn_raw;
    logic [W:0] up_raw;
    logic [W-1:0] dn_sat;
    logic [W-1:0] up_sat;

    always_comb begin
        dn_raw = {1'b0, thr} - {1'b0, step};
        up_raw = {1'b0, thr} + {1'b0, step};
        if (dn_raw[W] || dn_raw < MIN_X) begin
            dn_sat = MIN_X[W-1:0];
        end else begin
            dn_sat = dn_raw[W-1:0];
        end
        if (up_raw > MAX_X) begin
            up_sat = MAX_X[W-1:0];
        end else begin
            up_sat = up_raw[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr <= W'(INIT);
        end else if (raise) begin
            thr <= up_sat;
        end else if (lower) begin
            thr <= dn_sat;
        end
    end
endmodule

// File: rtl/agc_mask_gen.sv
module agc_mask_gen #(
    parameter int N  = 8,
    parameter int AW = 4
)(
    input  logic [AW-1:0] count,
    output logic [N-1:0]  mask
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign mask[i] = (count > AW'(i));
    end
endmodule

// File: rtl/adaptive_gate_ctrl.sv
module adaptive_gate_ctrl
    import agc_pkg::*;
#(
    parameter int N_ENG    = 8,
    parameter int QW       = 8,
    parameter int CNT_W    = 16,
    parameter int THR_MIN  = 4,
    parameter int THR_MAX  = 40,
    parameter int THR_INIT = 20,
    localparam int AW      = $clog2(N_ENG + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QW-1:0]     q_depth,
    input  logic [QW-1:0]     q_limit,
    input  logic              buf_full,
    input  logic [CNT_W-1:0]  step,
    input  logic [AW-1:0]     eng_count,
    output logic [N_ENG-1:0]  eng_en
);
    localparam logic [AW-1:0] ALL_ENG = AW'(N_ENG);
    localparam logic [AW-1:0] ONE_ENG = AW'(1);

    agc_state_e       st;
    agc_state_e       st_nx;
    logic [AW-1:0]    act;
    logic [AW-1:0]    act_eff;
    logic [AW-1:0]    lim_cnt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] thr;
    logic             can_grow;
    logic             can_trim;
    logic             cnt_inc;
    logic             cnt_clr;
    logic             thr_lower;
    logic             thr_raise;

    // Allowed engine count, clamped to 1..N_ENG
    always_comb begin
        if (eng_count == '0) begin
            lim_cnt = ONE_ENG;
        end else if (eng_count > ALL_ENG) begin
            lim_cnt = ALL_ENG;
        end else begin
            lim_cnt = eng_count;
        end
        act_eff  = (act > lim_cnt) ? lim_cnt : act;
        can_grow = (act_eff < lim_cnt);
        can_trim = (act_eff > ONE_ENG);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_WATCH;
        end else begin
            st <= st_nx;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_WATCH: begin
                if (buf_full) begin
                    st_nx = can_grow ? ST_WAKE : ST_WATCH;
                end else if (cnt > thr && can_trim) begin
                    st_nx = ST_SHED;
                end
            end
            ST_SHED:  st_nx = ST_WATCH;
            ST_WAKE:  st_nx = ST_WATCH;
            default:  st_nx = ST_WATCH;
        endcase
    end

    // Per-state action decode
    always_comb begin
        cnt_inc   = 1'b0;
        cnt_clr   = 1'b0;
        thr_lower = 1'b0;
        thr_raise = 1'b0;
        unique case (st)
            ST_WATCH: cnt_inc = (q_depth > q_limit);
            ST_SHED: begin
                cnt_clr   = 1'b1;
                thr_lower = can_trim;
            end
            ST_WAKE: begin
                cnt_clr   = 1'b1;
                thr_raise = can_grow;
            end
            default: cnt_clr = 1'b1;
        endcase
    end

    // Running-engine count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act <= ALL_ENG;
        end else begin
            unique case (st)
                ST_WATCH: act <= act_eff;
                ST_SHED:  act <= can_trim ? (act_eff - ONE_ENG) : act_eff;
                ST_WAKE:  act <= can_grow ? (act_eff + ONE_ENG) : act_eff;
                default:  act <= act_eff;
            endcase
        end
    end

    agc_sat_counter #(
        .W(CNT_W)
    ) u_pressure (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .clr   (cnt_clr),
        .value (cnt)
    );

    agc_adapt_thr #(
        .W    (CNT_W),
        .MIN  (THR_MIN),
        .MAX  (THR_MAX),
        .INIT (THR_INIT)
    ) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .lower (thr_lower),
        .raise (thr_raise),
        .step  (step),
        .thr   (thr)
    );

    agc_mask_gen #(
        .N  (N_ENG),
        .AW (AW)
    ) u_mask (
        .count (act_eff),
        .mask  (eng_en)
    );
endmodule

// File: rtl/adaptive_gate_ctrl_chk.sv
module adaptive_gate_ctrl_chk
    import agc_pkg::*;
#(
    parameter int N_ENG   = 8,
    parameter int AW      = 4,
    parameter int CNT_W   = 16,
    parameter int THR_MIN = 4,
    parameter int THR_MAX = 40
)(
    input logic             clk,
    input logic             rst_n,
    input logic             buf_full,
    input logic [AW-1:0]    eng_count,
    input logic [N_ENG-1:0] eng_en,
    input agc_state_e       st,
    input logic [AW-1:0]    act_eff,
    input logic [AW-1:0]    lim_cnt,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] thr
);
    // R11
    mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_en[0] && (((eng_en + N_ENG'(1)) & eng_en) == '0));

    // R6
    min_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(eng_en) >= 1);

    // R10
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(eng_count) |-> $countones(eng_en ^ $past(eng_en)) <= 1);

    // R4
    thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr >= CNT_W'(THR_MIN) && thr <= CNT_W'(THR_MAX));

    // R4
    shed_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_SHED |=> thr <= $past(thr));

    // R5
    wake_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_WAKE |=> thr >= $past(thr));

    // R3
    shed_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_SHED |=> cnt == '0);

    // R8
    full_blocks_shed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && st == ST_WATCH |=> st != ST_SHED);

    // R7
    full_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && st == ST_WATCH && act_eff >= lim_cnt |=> st != ST_WAKE);
endmodule

bind adaptive_gate_ctrl adaptive_gate_ctrl_chk #(
    .N_ENG   (N_ENG),
    .AW      (AW),
    .CNT_W   (CNT_W),
    .THR_MIN (THR_MIN),
    .THR_MAX (THR_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_full  (buf_full),
    .eng_count (eng_count),
    .eng_en    (eng_en),
    .st        (st),
    .act_eff   (act_eff),
    .lim_cnt   (lim_cnt),
    .cnt       (cnt),
    .thr       (thr)
);

// File: tb/adaptive_gate_ctrl_test.sv
`timescale 1ns/1ps
module adaptive_gate_ctrl_test;
    localparam int N  = 8;
    localparam int QW = 8;
    localparam int CW = 16;
    localparam int AW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [QW-1:0] q_depth = 8'd0;
    logic [QW-1:0] q_limit = 8'd10;
    logic          buf_full = 1'b0;
    logic [CW-1:0] step = 16'd8;
    logic [AW-1:0] eng_count = AW'(8);
    logic [N-1:0]  eng_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adaptive_gate_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_depth   (q_depth),
        .q_limit   (q_limit),
        .buf_full  (buf_full),
        .step      (step),
        .eng_count (eng_count),
        .eng_en    (eng_en)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Count edges until the mask changes, giving up after lim edges
    task automatic wait_change(output int n, input int lim);
        logic [N-1:0] prev;
        prev = eng_en;
        n = 0;
        while (n < lim) begin
            @(posedge clk);
            n++;
            #1;
            if (eng_en != prev) break;
        end
    endtask

    task automatic t_reset();
        check("R1 reset mask", int'(eng_en), 'hFF);
    endtask

    // R2 equal depth does not count; R3/R4/R10 trims with falling threshold
    task automatic t_shed_series();
        int n;
        q_depth = 8'd10;
        wait_change(n, 100);
        check("R2 depth equal to limit sheds nothing", int'(eng_en), 'hFF);
        q_depth = 8'd11;
        wait_change(n, 200);
        check("R3 first trim interval (thr 20)", n, 23);
        check("R10 highest engine trimmed first", int'(eng_en), 'h7F);
        wait_change(n, 200);
        check("R4 interval after lowering (thr 12)", n, 15);
        check("R10 mask after second trim", int'(eng_en), 'h3F);
        wait_change(n, 200);
        check("R4 interval at minimum (thr 4)", n, 7);
        wait_change(n, 200);
        check("R4 threshold held at minimum", n, 7);
        check("R11 mask after four trims", int'(eng_en), 'h0F);
    endtask

    // R6 floor of one engine
    task automatic t_floor();
        int n;
        wait_change(n, 200);
        wait_change(n, 200);
        wait_change(n, 200);
        check("R6 reach single engine", int'(eng_en), 'h01);
        wait_change(n, 60);
        check("R6 no trim below one engine", int'(eng_en), 'h01);
        q_depth = 8'd10;
    endtask

    // R5 single grow, then threshold inferred from next trim
    task automatic t_wake_one();
        int n;
        buf_full = 1'b1;
        @(posedge clk);
        #1;
        buf_full = 1'b0;
        check("R5 no change one edge after full", int'(eng_en), 'h01);
        @(posedge clk);
        #1;
        check("R5 lowest gated engine enabled", int'(eng_en), 'h03);
        q_depth = 8'd11;
        wait_change(n, 200);
        check("R5 threshold raised to 12 and counter cleared", n, 15);
        q_depth = 8'd10;
    endtask

    // R5 saturation at maximum, R7 ignored when all running
    task automatic t_wake_all();
        int n;
        logic [N-1:0] exp_mask;
        buf_full = 1'b1;
        exp_mask = 8'h01;
        for (int k = 0; k < 7; k++) begin
            wait_change(n, 10);
            exp_mask = {exp_mask[N-2:0], 1'b1};
            check("R5 grow every two edges", n, 2);
            check("R10 grow sets lowest cleared bit", int'(eng_en), int'(exp_mask));
        end
        wait_change(n, 20);
        check("R7 full ignored with all engines on", int'(eng_en), 'hFF);
        buf_full = 1'b0;
        q_depth = 8'd11;
        wait_change(n, 200);
        check("R5 threshold clamped at maximum 40", n, 43);
        check("R3 trim after saturation", int'(eng_en), 'h7F);
    endtask

    // R8 full buffer blocks trims despite pressure
    task automatic t_full_priority();
        int n;
        buf_full = 1'b1;
        wait_change(n, 10);
        check("R8 grow wins with pressure present", n, 2);
        wait_change(n, 100);
        check("R8 no trim while buffer full", int'(eng_en), 'hFF);
        buf_full = 1'b0;
        wait_change(n, 10);
        check("R8 trim follows release", n, 2);
        check("R8 mask after release", int'(eng_en), 'h7F);
        q_depth = 8'd10;
    endtask

    // R9 engine cap
    task automatic t_engine_limit();
        int n;
        eng_count = AW'(5);
        #1;
        check("R9 lowering cap shrinks mask", int'(eng_en), 'h1F);
        buf_full = 1'b1;
        wait_change(n, 10);
        check("R7 full ignored at cap", int'(eng_en), 'h1F);
        buf_full = 1'b0;
        eng_count = AW'(0);
        #1;
        check("R9 zero cap treated as one", int'(eng_en), 'h01);
        repeat (2) @(posedge clk);
        #1;
        eng_count = AW'(8);
        #1;
        check("R9 raising cap enables nothing", int'(eng_en), 'h01);
        wait_change(n, 5);
        check("R9 mask stays after raise", int'(eng_en), 'h01);
        eng_count = AW'(12);
        buf_full = 1'b1;
        for (int k = 0; k < 7; k++) wait_change(n, 10);
        buf_full = 1'b0;
        check("R9 cap above count treated as all", int'(eng_en), 'hFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mask after reset release", int'(eng_en), 'hFF);
        t_shed_series();
        t_floor();
        t_wake_one();
        t_wake_all();
        t_full_priority();
        t_engine_limit();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule